// File: doc/BRIEF.md
# Multiplexed Bus Register Interface

This block connects a host to a 128-byte register and storage map over a single 8-bit bus that carries both the address and the data. The host places an address on the bus and latches it with an address strobe. A data phase follows under one of two strobe protocols, chosen by a bus-type select pin. One protocol uses a data strobe with a read/write level. The other uses separate active-low read and write strobes. The first 14 bytes hold the clock, calendar and control registers. The remaining 114 bytes are general storage. Two of the 14 are read-only status registers.

All bus inputs are brought into the block clock domain through a synchronizer of configurable depth. Writes are committed when the write strobe ends. Reads are combinational from the latched address. A power-fail input blocks every write. It also forces the external SRAM chip enable, which otherwise passes straight through, to its inactive level.

Top module: `muxbus_regif`

## Requirements
- R1: The address is captured from the low 7 bits of the bus when the address strobe falls. Bit 7 of the bus is ignored for addressing.
- R2: With bus select high (strobe/level protocol), a write takes place while chip select is low and the data strobe is high with read/write low. The byte on the bus is stored when the data strobe falls.
- R3: With bus select high, the bus output is enabled and carries the addressed byte while chip select is low, the data strobe is high and read/write is high.
- R4: With bus select low (separate-strobe protocol), a low data strobe acts as the read strobe. With chip select low, it enables the bus output with the addressed byte.
- R5: With bus select low, a low read/write pin acts as the write strobe. The byte on the bus is stored when that pin returns high.
- R6: The bus output enable is low whenever chip select is high or no read strobe is active.
- R7: While the power-fail input is high, no write changes any location.
- R8: The external chip-enable output equals the external chip-enable input while the power-fail input is low. It is forced high while the power-fail input is high.
- R9: Offset 12 reads the status input and offset 13 reads 0x80 when power is good and 0x00 while it has failed. Writes to either offset have no effect.
- R10: A write strobe that begins while chip select is high stores nothing.
- R11: After reset every storage location reads 0x00 and the latched address is 0.
- R12: Every writable offset (0–11 and 14–127) holds its own byte independently of all other offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mot_i | input | 1 | Bus-type select: 1 strobe/level protocol, 0 separate strobes |
| cs_ni | input | 1 | Active-low chip select |
| as_i | input | 1 | Address strobe, address taken on falling edge |
| ds_i | input | 1 | Data strobe (high-active) or read strobe (low-active) |
| rw_i | input | 1 | Read/write level or active-low write strobe |
| ad_i | input | 8 | Multiplexed address/data bus, inbound |
| ad_o | output | 8 | Read data onto the bus |
| ad_oe_o | output | 1 | Bus output enable; low means high impedance |
| status_i | input | 8 | Flags presented at the read-only offset 12 |
| pwr_fail_i | input | 1 | Power-fail indication, high blocks writes |
| ram_ce_ni | input | 1 | External SRAM chip enable in, active low |
| ram_ce_no | output | 1 | External SRAM chip enable out, active low |

## Verification
A wrong latched address appears as the wrong byte on the bus during the next read strobe. That happens a synchronizer depth plus one cycle after the address strobe falls. A corrupted storage location stays hidden until its own offset is read back. For that reason every writable offset is written with a distinct value and then read back under the opposite protocol, which also exposes aliasing between offsets. A write leaking through power-fail or a deselected chip, or landing on a read-only offset, shows only as a changed read value on a later read of that offset.

// File: rtl/muxbus_regif_pkg.sv
package muxbus_regif_pkg;
  parameter int unsigned DATA_W    = 8;
  parameter int unsigned MAP_DEPTH = 128;
  parameter int unsigned ADDR_W    = $clog2(MAP_DEPTH);
  parameter int unsigned STAT_OFS  = 12;
  parameter int unsigned VALID_OFS = 13;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // synchronized bus bundle
  typedef struct packed {
    logic  mot;
    logic  cs_n;
    logic  as;
    logic  ds;
    logic  rw;
    logic  pf;
    byte_t ad;
  } bus_t;

  // idle levels: deselected, no write, power treated as failed
  localparam bus_t BUS_IDLE = '{mot: 1'b0, cs_n: 1'b1, as: 1'b0, ds: 1'b0,
                                rw: 1'b1, pf: 1'b1, ad: '0};
endpackage

// File: rtl/muxbus_regif_sync.sv
module muxbus_regif_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= RST_VAL;
          else         stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= RST_VAL;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/muxbus_regif_addr.sv
module muxbus_regif_addr
  import muxbus_regif_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  as_s_i,
  input  byte_t ad_s_i,
  output addr_t addr_o
);
  logic  as_q;
  addr_t addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      as_q <= as_s_i;
      if (as_q && !as_s_i) addr_q <= ad_s_i[ADDR_W-1:0];
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/muxbus_regif_wdec.sv
module muxbus_regif_wdec
  import muxbus_regif_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  bus_t  bus_s_i,
  output logic  wr_req_o,
  output byte_t wr_data_o
);
  logic  wr_act, wr_act_q, sel_q;
  byte_t data_q;

  // level protocol: ds high with rw low; strobe protocol: rw is active-low WR
  always_comb begin
    if (bus_s_i.mot) wr_act = bus_s_i.ds & ~bus_s_i.rw;
    else             wr_act = ~bus_s_i.rw;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      sel_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      wr_act_q <= wr_act;
      if (wr_act && !wr_act_q) sel_q <= ~bus_s_i.cs_n;
      if (wr_act)              data_q <= bus_s_i.ad;
    end
  end

  assign wr_req_o  = wr_act_q & ~wr_act & sel_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/muxbus_regif_store.sv
module muxbus_regif_store
  import muxbus_regif_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_req_i,
  input  logic  pf_s_i,
  input  addr_t waddr_i,
  input  byte_t wdata_i,
  input  addr_t raddr_i,
  input  byte_t status_i,
  input  logic  pf_i,
  output byte_t rd_data_o,
  output logic  mem_we_o
);
  byte_t mem_q [MAP_DEPTH];
  logic  ro_hit;

  assign ro_hit   = (waddr_i == addr_t'(STAT_OFS)) || (waddr_i == addr_t'(VALID_OFS));
  assign mem_we_o = wr_req_i & ~pf_s_i & ~ro_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MAP_DEPTH; i++) mem_q[i] <= '0;
    end else if (mem_we_o) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_comb begin
    if (raddr_i == addr_t'(STAT_OFS))       rd_data_o = status_i;
    else if (raddr_i == addr_t'(VALID_OFS)) rd_data_o = {~pf_i, {(DATA_W-1){1'b0}}};
    else                                    rd_data_o = mem_q[raddr_i];
  end
endmodule

// File: rtl/muxbus_regif.sv
module muxbus_regif
  import muxbus_regif_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mot_i,
  input  logic        cs_ni,
  input  logic        as_i,
  input  logic        ds_i,
  input  logic        rw_i,
  input  logic [7:0]  ad_i,
  output logic [7:0]  ad_o,
  output logic        ad_oe_o,
  input  logic [7:0]  status_i,
  input  logic        pwr_fail_i,
  input  logic        ram_ce_ni,
  output logic        ram_ce_no
);
  localparam int unsigned BUS_W = $bits(bus_t);

  bus_t  bus_raw, bus_s;
  addr_t addr_q;
  logic  wr_req, mem_we;
  byte_t wr_data, rd_data;
  logic  rd_act;

  assign bus_raw = '{mot: mot_i, cs_n: cs_ni, as: as_i, ds: ds_i,
                     rw: rw_i, pf: pwr_fail_i, ad: ad_i};

  muxbus_regif_sync #(
    .WIDTH  (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUS_IDLE)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_raw),
    .q_o   (bus_s)
  );

  muxbus_regif_addr i_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .as_s_i(bus_s.as),
    .ad_s_i(bus_s.ad),
    .addr_o(addr_q)
  );

  muxbus_regif_wdec i_wdec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_s_i  (bus_s),
    .wr_req_o (wr_req),
    .wr_data_o(wr_data)
  );

  muxbus_regif_store i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (wr_req),
    .pf_s_i   (bus_s.pf),
    .waddr_i  (addr_q),
    .wdata_i  (wr_data),
    .raddr_i  (addr_q),
    .status_i (status_i),
    .pf_i     (pwr_fail_i),
    .rd_data_o(rd_data),
    .mem_we_o (mem_we)
  );

  // read strobe straight from the pins so the bus turns around without delay
  assign rd_act    = mot_i ? (ds_i & rw_i) : ~ds_i;
  assign ad_oe_o   = ~cs_ni & rd_act;
  assign ad_o      = rd_data;
  assign ram_ce_no = ram_ce_ni | pwr_fail_i;
endmodule

// File: rtl/muxbus_regif_chk.sv
module muxbus_regif_chk
  import muxbus_regif_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  cs_ni,
  input logic  pwr_fail_i,
  input logic  ram_ce_no,
  input logic  ad_oe_o,
  input logic [7:0] ad_o,
  input logic  as_s,
  input byte_t ad_s,
  input addr_t addr_q,
  input logic  mem_we
);
  assert_addr_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(as_s) |=> addr_q == $past(ad_s[ADDR_W-1:0]));

  assert_bus_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> !cs_ni);

  assert_ce_forced_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |-> ram_ce_no);

  assert_valid_bits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && addr_q == addr_t'(VALID_OFS)) |-> ad_o[6:0] == 7'd0);

  // storage byte under a steady read stays put unless a write landed
  assert_read_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ad_oe_o && $past(ad_oe_o) && $stable(addr_q) && !$past(mem_we)
     && addr_q != addr_t'(STAT_OFS) && addr_q != addr_t'(VALID_OFS)) |-> $stable(ad_o));
endmodule

bind muxbus_regif muxbus_regif_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .pwr_fail_i(pwr_fail_i),
  .ram_ce_no (ram_ce_no),
  .ad_oe_o   (ad_oe_o),
  .ad_o      (ad_o),
  .as_s      (bus_s.as),
  .ad_s      (bus_s.ad),
  .addr_q    (addr_q),
  .mem_we    (mem_we)
);

// File: tb/test_muxbus_regif.sv
module test_muxbus_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mot = 1'b1, cs_n = 1'b1, as_s = 1'b0, ds = 1'b0, rw = 1'b1;
  logic [7:0] ad = '0, status = 8'h3C;
  logic       pf = 1'b0, ce_in = 1'b0;
  logic [7:0] ad_out;
  logic       oe, ce_out;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] exp_mem [128];

  always #10 clk = ~clk;

  muxbus_regif i_muxbus_regif (
    .clk_i(clk), .rst_ni(rst_n), .mot_i(mot), .cs_ni(cs_n), .as_i(as_s),
    .ds_i(ds), .rw_i(rw), .ad_i(ad), .ad_o(ad_out), .ad_oe_o(oe),
    .status_i(status), .pwr_fail_i(pf), .ram_ce_ni(ce_in), .ram_ce_no(ce_out)
  );

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic m);
    cs_n = 1'b1;
    wait_cyc(1);
    mot = m;
    ds  = m ? 1'b0 : 1'b1;
    rw  = 1'b1;
    wait_cyc(4);
  endtask

  task automatic addr_phase(logic [7:0] a);
    ad = a; as_s = 1'b1;
    wait_cyc(3);
    as_s = 1'b0;
    wait_cyc(4);
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d, logic sel);
    cs_n = ~sel;
    addr_phase(a);
    ad = d;
    if (mot) begin
      rw = 1'b0; wait_cyc(1); ds = 1'b1; wait_cyc(4);
      ds = 1'b0; wait_cyc(4); rw = 1'b1;
    end else begin
      rw = 1'b0; wait_cyc(4); rw = 1'b1; wait_cyc(4);
    end
    cs_n = 1'b1;
    wait_cyc(2);
  endtask

  task automatic bus_read(logic [7:0] a, output logic [7:0] d, output logic en);
    cs_n = 1'b0;
    addr_phase(a);
    if (mot) ds = 1'b1; else ds = 1'b0;
    wait_cyc(2);
    d = ad_out; en = oe;
    ds = mot ? 1'b0 : 1'b1;
    wait_cyc(1);
    cs_n = 1'b1;
    wait_cyc(2);
  endtask

  function automatic logic [7:0] exp_read(int a);
    if (a == 12) return status;
    if (a == 13) return {~pf, 7'd0};
    return exp_mem[a];
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic en;
    for (int i = 0; i < 128; i++) exp_mem[i] = '0;
    wait_cyc(3);
    check("R6 reset oe", {7'd0, oe}, 8'h00);
    rst_n = 1'b1;
    wait_cyc(4);

    // R11: reset contents and address
    set_mode(1'b0);
    cs_n = 1'b0; ds = 1'b0; wait_cyc(2);
    check("R11 addr0 after reset", ad_out, 8'h00);
    check("R4 oe intel read", {7'd0, oe}, 8'h01);
    ds = 1'b1; wait_cyc(1);
    check("R6 oe intel idle", {7'd0, oe}, 8'h00);
    cs_n = 1'b1;
    bus_read(8'd77, d, en);
    check("R11 storage zero", d, 8'h00);

    // R2 + R4 + R12: write all via level protocol, read all via strobe protocol
    set_mode(1'b1);
    for (int a = 0; a < 128; a++) begin
      bus_write(8'(a), 8'(a * 37 + 5), 1'b1);
      if (a != 12 && a != 13) exp_mem[a] = 8'(a * 37 + 5);
    end
    set_mode(1'b0);
    for (int a = 0; a < 128; a++) begin
      bus_read(8'(a), d, en);
      check((a == 12 || a == 13) ? "R9 ro after write" : "R12 R2 R4 sweep", d, exp_read(a));
    end

    // R5 + R3: write via strobe protocol, read via level protocol
    for (int a = 0; a < 128; a++) begin
      bus_write(8'(a), 8'(a) ^ 8'hA5, 1'b1);
      if (a != 12 && a != 13) exp_mem[a] = 8'(a) ^ 8'hA5;
    end
    set_mode(1'b1);
    for (int a = 0; a < 128; a++) begin
      bus_read(8'(a), d, en);
      check("R12 R5 R3 sweep", d, exp_read(a));
      check("R3 oe level read", {7'd0, en}, 8'h01);
    end

    // R6: level protocol, deselected or write-direction strobe
    cs_n = 1'b1; ds = 1'b1; rw = 1'b1; wait_cyc(1);
    check("R6 oe deselected", {7'd0, oe}, 8'h00);
    cs_n = 1'b0; rw = 1'b0; wait_cyc(1);
    check("R6 oe write dir", {7'd0, oe}, 8'h00);
    ds = 1'b0; wait_cyc(1); rw = 1'b1; cs_n = 1'b1; wait_cyc(4);

    // R1: bit 7 ignored
    bus_read(8'h85, d, en);
    check("R1 bit7 ignored", d, exp_mem[5]);
    bus_write(8'h83, 8'h5A, 1'b1); exp_mem[3] = 8'h5A;
    bus_read(8'd3, d, en);
    check("R1 write bit7 ignored", d, 8'h5A);

    // R9: status reflects input
    status = 8'hC3;
    bus_read(8'd12, d, en);
    check("R9 status input", d, 8'hC3);
    bus_write(8'd12, 8'hFF, 1'b1);
    bus_read(8'd12, d, en);
    check("R9 status write ignored", d, 8'hC3);

    // R10: deselected write ignored
    bus_write(8'd40, 8'h11, 1'b0);
    bus_read(8'd40, d, en);
    check("R10 deselected write", d, exp_mem[40]);
    set_mode(1'b0);
    bus_write(8'd41, 8'h22, 1'b0);
    bus_read(8'd41, d, en);
    check("R10 deselected intel write", d, exp_mem[41]);

    // R7 + R8
    ce_in = 1'b0; wait_cyc(1);
    check("R8 ce pass low", {7'd0, ce_out}, 8'h00);
    ce_in = 1'b1; wait_cyc(1);
    check("R8 ce pass high", {7'd0, ce_out}, 8'h01);
    ce_in = 1'b0; pf = 1'b1; wait_cyc(4);
    check("R8 ce forced", {7'd0, ce_out}, 8'h01);
    bus_write(8'd50, 8'h99, 1'b1);
    set_mode(1'b1);
    bus_write(8'd51, 8'h98, 1'b1);
    bus_read(8'd13, d, en);
    check("R9 valid low on fail", d, 8'h00);
    pf = 1'b0; wait_cyc(4);
    check("R8 ce released", {7'd0, ce_out}, 8'h00);
    bus_read(8'd50, d, en);
    check("R7 blocked intel write", d, exp_mem[50]);
    bus_read(8'd51, d, en);
    check("R7 blocked level write", d, exp_mem[51]);
    bus_read(8'd13, d, en);
    check("R9 valid high", d, 8'h80);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule